// File: doc/BRIEF.md
# Multi-Segment Parallel Display Bus Engine

This block carries out one byte transfer at a time on an 8-bit bidirectional parallel bus. The bus serves a graphic display built from four side-by-side controller segments, each with its own chip select. A request carries the byte, a flag saying whether it is pixel data or a controller command, and the two top bits of the horizontal cursor. Those two bits name the addressed segment. Before every write, the engine releases the bus and reads the addressed segment's status. It strobes the enable line repeatedly until status bit 7 reads low. It then drives the byte with the right register-select level and pulses enable once.

Commands are broadcast to all four segments, while data and status reads address only one. A polarity input turns all chip selects active low. If a segment stays busy for the whole poll budget, the engine marks it dead in a sticky mask and drops the transfer. From then on, any request aimed at that segment is acknowledged at once without touching the bus. Only reset clears the mask.

Top module: `panel_bus_engine`

## Requirements
- R1: The addressed segment is `req_col_hi`: value 0 selects `pin_cs[0]`, 1 selects `pin_cs[1]`, 2 selects `pin_cs[2]` and 3 selects `pin_cs[3]`. During status reads and data writes, exactly that one chip select is active.
- R2: During a command write (`req_is_data` = 0), all four chip selects are active.
- R3: When `cs_active_low` is 1, every chip-select output is inverted, so active means 0. When it is 0, active means 1.
- R4: While status is polled, `bus_oe` is 0, `pin_rs` is 0 and `pin_rw` is 1.
- R5: Each status read is one enable pulse. `bus_in[7]` is sampled in the last cycle that enable is high. A 1 means busy and triggers another read. A 0 moves on to the write, so a segment busy for k reads is read k+1 times.
- R6: At most 2^POLL_W-1 status reads are made per transfer. If all of them read busy, the segment's bit is set in `dead_mask`, no write follows, and `done` still pulses.
- R7: A request to a segment whose `dead_mask` bit is set produces no enable pulse and no status read, and it is acknowledged with `done`.
- R8: During a write, `bus_oe` is 1, `bus_out` carries the request byte, `pin_rw` is 0, and `pin_rs` equals `req_is_data`.
- R9: Every enable pulse is high for exactly E_HIGH_CYC cycles. Enable stays low for at least E_LOW_CYC cycles before each rise.
- R10: `dead_mask` is 0 after reset. Bits are only ever added to it, and only reset clears it.
- R11: Each request accepted while idle is answered by exactly one `done` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request, sampled while idle |
| req_byte | input | 8 | Byte to write |
| req_is_data | input | 1 | 1 = data write, 0 = command |
| req_col_hi | input | 2 | Cursor X[7:6], addressed segment |
| cs_active_low | input | 1 | Chip-select polarity option |
| bus_in | input | 8 | Bus value read from the display |
| bus_out | output | 8 | Bus value driven to the display |
| bus_oe | output | 1 | Bus driver enable (0 = released) |
| pin_e | output | 1 | Enable strobe |
| pin_rs | output | 1 | Register select (1 = data) |
| pin_rw | output | 1 | 1 = read, 0 = write |
| pin_cs | output | 4 | Segment chip selects |
| done | output | 1 | Transfer finished or skipped |
| dead_mask | output | 4 | Sticky timed-out segment mask |

## Verification
The bench builds the engine with E_HIGH_CYC = 2, E_LOW_CYC = 3 and POLL_W = 4. This makes the poll budget 15 reads, so both sides of the timeout boundary are reached in a few hundred cycles. A segment busy for 14 reads still gets its write, while one busy for 15 is declared dead. The short strobe counts also let every pulse width and gap be measured exactly.

// File: rtl/pbe_pkg.sv
// Shared constants and phase encoding for the parallel display bus engine.
// Assumes a fixed four-segment panel addressed by two cursor bits.
package pbe_pkg;
    localparam int SEG_BITS = 2;
    localparam int NSEG     = 1 << SEG_BITS;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_POLL_LO,
        PH_POLL_HI,
        PH_WR_LO,
        PH_WR_HI,
        PH_ACK
    } phase_e;
endpackage

// File: rtl/pbe_cs_map.sv
// Chip-select generator: decodes the addressed segment, or broadcasts to all
// segments, and applies the output polarity. Assumes seg is stable while enable is set.
module pbe_cs_map
    import pbe_pkg::*;
(
    input  logic [SEG_BITS-1:0] seg,
    input  logic                enable,
    input  logic                broadcast,
    input  logic                active_low,
    output logic [NSEG-1:0]     cs
);
    // One select line per segment, each with its polarity applied.
    for (genvar g = 0; g < NSEG; g++) begin : g_line
        logic hit;
        assign hit   = enable && (broadcast || (seg == SEG_BITS'(g)));
        assign cs[g] = hit ^ active_low;
    end
endmodule

// File: rtl/pbe_phase_timer.sv
// Down-counter that times strobe phases. Loading N makes expired true
// N cycles later, so a phase entered with load value N-1 lasts N cycles.
module pbe_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pbe_seg_guard.sv
// Sticky record of segments that never reported ready. Answers whether a
// probed segment is dead. Assumes only reset may revive a segment.
module pbe_seg_guard
    import pbe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEG_BITS-1:0] probe_seg,
    output logic                probe_dead,
    input  logic                kill,
    input  logic [SEG_BITS-1:0] kill_seg,
    output logic [NSEG-1:0]     dead_mask
);
    // Accumulate timed-out segments; bits are never removed.
    always_ff @(posedge clk) begin
        if (!rst_n)    dead_mask <= '0;
        else if (kill) dead_mask <= dead_mask | (NSEG'(1) << kill_seg);
    end

    assign probe_dead = dead_mask[probe_seg];
endmodule

// File: rtl/panel_bus_engine.sv
// Sequencer for single byte writes to a four-segment parallel display.
// Flow: poll the status of the addressed segment until ready, then write.
// A bounded poll count retires a segment that never becomes ready.
// Assumes req_valid is only looked at while idle, and that E_HIGH_CYC and
// E_LOW_CYC are both at least 1.
module panel_bus_engine
    import pbe_pkg::*;
#(
    parameter int E_HIGH_CYC = 113,
    parameter int E_LOW_CYC  = 113,
    parameter int POLL_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [7:0]          req_byte,
    input  logic                req_is_data,
    input  logic [SEG_BITS-1:0] req_col_hi,
    input  logic                cs_active_low,
    input  logic [7:0]          bus_in,
    output logic [7:0]          bus_out,
    output logic                bus_oe,
    output logic                pin_e,
    output logic                pin_rs,
    output logic                pin_rw,
    output logic [NSEG-1:0]     pin_cs,
    output logic                done,
    output logic [NSEG-1:0]     dead_mask
);
    localparam int TMAX = (E_HIGH_CYC > E_LOW_CYC) ? E_HIGH_CYC : E_LOW_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LD_HIGH = TW'(E_HIGH_CYC - 1);
    localparam logic [TW-1:0] LD_LOW  = TW'(E_LOW_CYC - 1);

    phase_e              ph, ph_nx;
    logic [7:0]          byte_q;
    logic                data_q;
    logic [SEG_BITS-1:0] seg_q;
    logic [POLL_W-1:0]   poll_cnt;
    logic                tmr_load, tmr_done;
    logic [TW-1:0]       tmr_val;
    logic                kill, req_dead;
    logic                polling, writing;
    logic                unused_bits;

    assign unused_bits = ^bus_in[6:0];

    pbe_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_done)
    );

    pbe_seg_guard u_guard (
        .clk(clk), .rst_n(rst_n), .probe_seg(req_col_hi),
        .probe_dead(req_dead), .kill(kill), .kill_seg(seg_q),
        .dead_mask(dead_mask)
    );

    // Next-phase selection and timer loads.
    always_comb begin
        ph_nx    = ph;
        tmr_load = 1'b0;
        tmr_val  = LD_LOW;
        kill     = 1'b0;
        unique case (ph)
            PH_IDLE: if (req_valid) begin
                if (req_dead) ph_nx = PH_ACK;
                else begin ph_nx = PH_POLL_LO; tmr_load = 1'b1; end
            end
            PH_POLL_LO: if (tmr_done) begin
                if (poll_cnt == '1) begin kill = 1'b1; ph_nx = PH_ACK; end
                else begin ph_nx = PH_POLL_HI; tmr_load = 1'b1; tmr_val = LD_HIGH; end
            end
            PH_POLL_HI: if (tmr_done) begin
                ph_nx    = bus_in[7] ? PH_POLL_LO : PH_WR_LO;
                tmr_load = 1'b1;
            end
            PH_WR_LO: if (tmr_done) begin
                ph_nx = PH_WR_HI; tmr_load = 1'b1; tmr_val = LD_HIGH;
            end
            PH_WR_HI: if (tmr_done) ph_nx = PH_ACK;
            PH_ACK:   ph_nx = PH_IDLE;
            default:  ph_nx = PH_IDLE;
        endcase
    end

    // Phase register, request capture and poll budget counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            byte_q   <= '0;
            data_q   <= 1'b0;
            seg_q    <= '0;
            poll_cnt <= '0;
        end else begin
            ph <= ph_nx;
            if (ph == PH_IDLE && req_valid) begin
                byte_q   <= req_byte;
                data_q   <= req_is_data;
                seg_q    <= req_col_hi;
                poll_cnt <= '0;
            end else if (ph == PH_POLL_LO && tmr_done && poll_cnt != '1) begin
                poll_cnt <= poll_cnt + 1'b1;
            end
        end
    end

    assign polling = (ph == PH_POLL_LO) || (ph == PH_POLL_HI);
    assign writing = (ph == PH_WR_LO)   || (ph == PH_WR_HI);

    // Pin decode from the current phase.
    assign pin_e   = (ph == PH_POLL_HI) || (ph == PH_WR_HI);
    assign pin_rw  = polling;
    assign pin_rs  = writing && data_q;
    assign bus_oe  = !polling;
    assign bus_out = byte_q;
    assign done    = (ph == PH_ACK);

    pbe_cs_map u_cs (
        .seg(seg_q), .enable(polling || writing),
        .broadcast(writing && !data_q), .active_low(cs_active_low),
        .cs(pin_cs)
    );
endmodule

// File: rtl/pbe_checker.sv
// Protocol checker for panel_bus_engine, attached by bind below.
// Watches only the pins and the status output.
module pbe_checker
    import pbe_pkg::*;
#(
    parameter int E_HIGH_CYC = 113,
    parameter int E_LOW_CYC  = 113
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pin_e,
    input logic            pin_rw,
    input logic            pin_rs,
    input logic            bus_oe,
    input logic [NSEG-1:0] pin_cs,
    input logic            cs_active_low,
    input logic            done,
    input logic [NSEG-1:0] dead_mask
);
    logic [NSEG-1:0] cs_true;
    logic [15:0]     hi_run, lo_run;

    assign cs_true = pin_cs ^ {NSEG{cs_active_low}};

    // Saturating run lengths of the enable line at each level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else if (pin_e) begin
            hi_run <= (hi_run == '1) ? hi_run : hi_run + 1'b1;
            lo_run <= '0;
        end else begin
            lo_run <= (lo_run == '1) ? lo_run : lo_run + 1'b1;
            hi_run <= '0;
        end
    end

    // R4
    poll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rw |-> (!bus_oe && !pin_rs));
    // R8
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_e && !pin_rw) |-> bus_oe);
    // R2
    cmd_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_e && !pin_rw && !pin_rs) |-> (cs_true == '1));
    // R1
    single_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_e && (pin_rw || pin_rs)) |-> ($countones(cs_true) == 1));
    // R9
    e_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_e && hi_run != '0) |-> (hi_run == 16'(E_HIGH_CYC)));
    // R9
    e_low_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_e && lo_run != '0) |-> (lo_run >= 16'(E_LOW_CYC)));
    // R10
    dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_mask & $past(dead_mask)) == $past(dead_mask)));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind panel_bus_engine pbe_checker #(
    .E_HIGH_CYC(E_HIGH_CYC), .E_LOW_CYC(E_LOW_CYC)
) u_pbe_chk (
    .clk(clk), .rst_n(rst_n), .pin_e(pin_e), .pin_rw(pin_rw),
    .pin_rs(pin_rs), .bus_oe(bus_oe), .pin_cs(pin_cs),
    .cs_active_low(cs_active_low), .done(done), .dead_mask(dead_mask)
);

// File: tb/panel_bus_engine_bench.sv
module panel_bus_engine_bench;
    localparam int EH   = 2;
    localparam int EL   = 3;
    localparam int PW   = 4;
    localparam int MAXP = (1 << PW) - 1;

    typedef struct {
        logic [3:0] cs_raw;
        logic       rs;
        logic [7:0] b;
        int         writes;
        int         polls;
        logic [3:0] mask;
    } exp_t;

    logic       clk = 0, rst_n = 0;
    logic       req_valid = 0, req_is_data = 0, cs_active_low = 0;
    logic [7:0] req_byte = 0;
    logic [1:0] req_col_hi = 0;
    logic [7:0] bus_in, bus_out;
    logic       bus_oe, pin_e, pin_rs, pin_rw, done;
    logic [3:0] pin_cs, dead_mask;

    int checks = 0, fails = 0;
    int busy_left[4];
    logic [3:0] bench_dead = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    panel_bus_engine #(.E_HIGH_CYC(EH), .E_LOW_CYC(EL), .POLL_W(PW)) u_panel_bus_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
        .req_is_data(req_is_data), .req_col_hi(req_col_hi),
        .cs_active_low(cs_active_low), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .pin_e(pin_e), .pin_rs(pin_rs), .pin_rw(pin_rw),
        .pin_cs(pin_cs), .done(done), .dead_mask(dead_mask)
    );

    // Display model: busy while the addressed segment has reads left to burn.
    logic [3:0] live_cs;
    int         live_seg;
    always_comb begin
        live_cs  = pin_cs ^ {4{cs_active_low}};
        live_seg = 0;
        for (int i = 0; i < 4; i++) if (live_cs[i]) live_seg = i;
        bus_in = {busy_left[live_seg] > 0, 7'h2A};
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: watch strobes, count reads, capture writes, score on done.
    bit         prev_e = 0, was_read = 0;
    int         hi_len = 0, polls = 0, wr_n = 0, poll_seg = 0;
    logic [3:0] wr_cs = 0;
    logic       wr_rs = 0;
    logic [7:0] wr_b = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pin_e && !prev_e) begin
                hi_len   = 0;
                was_read = pin_rw;
                if (!pin_rw) begin
                    wr_n++; wr_cs = pin_cs; wr_rs = pin_rs; wr_b = bus_out;
                    chk(bus_oe == 1, "R8", "bus_oe at write", bus_oe, 1);
                end else begin
                    poll_seg = live_seg;
                    chk(!bus_oe && !pin_rs, "R4", "oe/rs during read", {bus_oe, pin_rs}, 0);
                    chk($countones(live_cs) == 1, "R1", "read selects", $countones(live_cs), 1);
                end
            end
            if (pin_e) hi_len++;
            if (!pin_e && prev_e) begin
                chk(hi_len == EH, "R9", "enable high width", hi_len, EH);
                if (was_read) begin
                    polls++;
                    if (busy_left[poll_seg] > 0) busy_left[poll_seg]--;
                end
            end
            if (done) begin
                exp_t e;
                if (q.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(wr_n == e.writes, "R5/R6/R7", "write count", wr_n, e.writes);
                    chk(polls == e.polls, "R5/R6", "status reads", polls, e.polls);
                    if (e.writes == 1 && wr_n == 1) begin
                        chk(wr_cs == e.cs_raw, "R1/R2/R3", "chip selects", wr_cs, e.cs_raw);
                        chk(wr_rs == e.rs, "R8", "register select", wr_rs, e.rs);
                        chk(wr_b == e.b, "R8", "bus byte", wr_b, e.b);
                    end
                    chk(dead_mask == e.mask, "R6/R10", "dead mask", dead_mask, e.mask);
                end
                polls = 0; wr_n = 0;
            end
        end
        prev_e = pin_e;
    end

    // Driver: predict the outcome, push it, issue the request, await done.
    task automatic xfer(input bit d, input int seg, input logic [7:0] b,
                        input bit pol, input int busy);
        exp_t e;
        logic [3:0] tru;
        int n = 0;
        cs_active_low = pol;
        busy_left[seg] = busy;
        tru = d ? (4'b0001 << seg) : 4'b1111;
        e.cs_raw = pol ? ~tru : tru;
        e.rs = d; e.b = b;
        if (bench_dead[seg]) begin
            e.writes = 0; e.polls = 0;
        end else if (busy >= MAXP) begin
            e.writes = 0; e.polls = MAXP; bench_dead[seg] = 1'b1;
        end else begin
            e.writes = 1; e.polls = busy + 1;
        end
        e.mask = bench_dead;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_is_data = d; req_byte = b; req_col_hi = 2'(seg);
        @(negedge clk);
        req_valid = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk(done == 0, "R11", "done width", done, 0);
        busy_left[seg] = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R11 watchdog: actual 0 expected 1 completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) busy_left[i] = 0;
        repeat (3) @(negedge clk);
        chk(dead_mask == 0, "R10", "reset mask", dead_mask, 0);
        chk(pin_e == 0 && done == 0, "R11", "reset e/done", {pin_e, done}, 0);
        chk(bus_oe == 1, "R4", "reset bus driven", bus_oe, 1);
        rst_n = 1;
        @(negedge clk);
        xfer(0, 0, 8'h3F, 0, 0);   // R2 command broadcast
        xfer(1, 1, 8'hA5, 0, 2);   // R1 R5 data to segment 1
        xfer(1, 2, 8'h5A, 0, 5);   // R5 longer busy
        xfer(1, 3, 8'hC3, 1, 1);   // R3 inverted selects
        xfer(0, 2, 8'hB8, 1, 0);   // R2 R3 command inverted
        xfer(1, 0, 8'h01, 0, 0);   // R1 segment 0
        xfer(1, 3, 8'h7E, 0, MAXP - 1); // R6 boundary: still written
        xfer(1, 1, 8'hEE, 0, MAXP);     // R6 timeout kills segment 1
        xfer(1, 1, 8'h11, 0, 0);   // R7 skipped data
        xfer(0, 1, 8'h40, 0, 0);   // R7 skipped command
        xfer(1, 0, 8'h99, 1, 3);   // R10 mask sticky, other segments live
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk(dead_mask == 0, "R10", "mask after reset", dead_mask, 0);
        rst_n = 1; bench_dead = 0;
        xfer(1, 1, 8'h22, 0, 0);   // R10 revived segment written
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule